// File: doc/BRIEF.md
# Network Interface Control and Parity Error Capture Registers

This block holds the control word a host uses to steer a network interface board, and the registers that record a buffer-memory parity error. Through the control word the host holds the board in reset, releases the interface from loopback, wakes the on-board controller with an attention pulse, and enables interrupts. It also sets a few static configuration bits that are passed straight out: an expansion-bus enable, a RAM device size select and a 4-bit extension of the host address.

Two event sources arrive as single-cycle pulses. One is an interrupt request from the controller and the other is a parity error from buffer memory. Each sets a sticky flag. The parity error also records where it happened (a 16-bit low address word and a 4-bit high address field), which side reported it, and which byte half failed. That record is frozen at the first error and stays frozen until the host acknowledges it. One interrupt output combines both flags, each gated by its own enable.

The host reaches the registers through a single-cycle write strobe with a 2-bit register select. Reads are combinational on the same select.

Top module: `nic_ctl_regs`

## Requirements
- R1: Status bit 15 is stored on a write to select 0 (the status word) and drives `board_rst` from the next cycle onward.
- R2: Status bits 14, 5, 4 and 3..0 are stored on a status write and drive `on_air`, `p2_enable`, `ram_256k` and `ext_haddr`. Bits 12 (controller interrupt enable) and 11 (parity interrupt enable) are stored and read back.
- R3: `attn_pulse` is high for exactly one cycle, in the cycle after a status write that sets bit 13 while the stored bit 13 is 0. A write that leaves bit 13 at 1 gives no pulse.
- R4: A `ctrl_irq_pulse` sets the controller interrupt flag, read as status bit 8. The flag stays set until a status write with bit 8 equal to 1 clears it. A pulse in the same cycle as that write wins, and the flag stays set.
- R5: While the stored reset bit is 1, the controller interrupt flag is cleared on every cycle and incoming interrupt pulses are ignored.
- R6: A `par_err_pulse` sets the parity flag (status bit 9). When the flag was clear, the same pulse captures the address (low 16 bits read at select 2), the source (select 1, bit 7), the byte half (select 1, bit 6) and the high address bits (select 1, bits 3..0). Later errors leave the captured fields unchanged while the flag is set.
- R7: Writing select 1 with bit 8 equal to 1 clears the parity flag. An error in the same cycle is captured and keeps the flag set. Bit 8 of select 1 always reads 0. All other bits of selects 1 and 2, and status bits 8 and 9, cannot be changed by a write except through the clear rules above.
- R8: `irq_out` is 1 exactly when (controller flag AND bit 12) OR (parity flag AND bit 11).
- R9: Status bits 10, 7 and 6, select 1 bits 15..9 and 5..4, and every bit at select 3 read 0.
- R10: After reset every stored bit, flag and captured field is 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 2 | Register select: 0 status, 1 parity control, 2 parity address low, 3 none |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_sel` (combinational) |
| ctrl_irq_pulse | input | 1 | Interrupt request pulse from the controller |
| par_err_pulse | input | 1 | Parity error pulse from buffer memory |
| par_err_addr | input | 20 | Failing address: low 16 bits, then 4 high bits |
| par_err_src | input | 1 | Side that reported the parity error |
| par_err_half | input | 1 | Byte half that failed |
| board_rst | output | 1 | Board reset, held while status bit 15 is set |
| on_air | output | 1 | Loopback release |
| attn_pulse | output | 1 | One-cycle attention to the controller |
| p2_enable | output | 1 | Expansion bus enable |
| ram_256k | output | 1 | RAM device size select |
| ext_haddr | output | 4 | Host address extension bits |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that the attention pulse never lasts two cycles and always follows a status write with bit 13 set, that the controller flag stays clear while the board is held in reset, and that a pending parity record stays frozen until acknowledged. They also check that an acknowledge with no new error clears the parity flag, that a pending enabled parity flag always raises the interrupt, and that each event pulse sets its flag. Some behaviour only the bench scenarios can show: the exact captured values, which of two same-cycle events wins, and the read-back of every register layout. The bench shows these by comparing against a step-by-step model while random writes, pulses and addresses are interleaved with directed sequences.

// File: rtl/nic_ctl_pkg.sv
// Shared constants and types for the interface control registers.
// Bit positions are fixed by the host register layout.
package nic_ctl_pkg;

    localparam int REG_W      = 16;
    localparam int ERR_LO_W   = 16;
    localparam int ERR_HI_W   = 4;

    // status word layout
    localparam int ST_RESET   = 15;
    localparam int ST_ONAIR   = 14;
    localparam int ST_ATTN    = 13;
    localparam int ST_IEN     = 12;
    localparam int ST_PIEN    = 11;
    localparam int ST_PFLAG   = 9;
    localparam int ST_IFLAG   = 8;
    localparam int ST_P2      = 5;
    localparam int ST_RAM256  = 4;

    // parity control layout
    localparam int PC_ACK     = 8;
    localparam int PC_SRC     = 7;
    localparam int PC_HALF    = 6;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_PCTRL  = 2'd1,
        SEL_PADDR  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                src;
        logic                half;
        logic [ERR_HI_W-1:0] hi;
        logic [ERR_LO_W-1:0] lo;
    } perr_rec_t;

    // Mask of the host-writable status bits (control plus configuration)
    function automatic logic [REG_W-1:0] ctl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[ST_RESET]  = 1'b1;
        m[ST_ONAIR]  = 1'b1;
        m[ST_ATTN]   = 1'b1;
        m[ST_IEN]    = 1'b1;
        m[ST_PIEN]   = 1'b1;
        m[ST_P2]     = 1'b1;
        m[ST_RAM256] = 1'b1;
        for (int i = 0; i < ERR_HI_W; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/nic_ctl_status.sv
// Status word storage: writable control bits, the sticky controller
// interrupt flag and the attention pulse generator.
// Assumes single-cycle write strobes and single-cycle interrupt pulses.
module nic_ctl_status
    import nic_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    input  logic         irq_pulse,
    output logic [W-1:0] ctl_q,
    output logic         irq_flag,
    output logic         attn_pulse
);

    localparam logic [W-1:0] MASK = W'(ctl_mask());

    logic irq_clear;
    assign irq_clear = wr_stat & wdata[ST_IFLAG];

    // Purpose: hold the host-written control and configuration bits
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_q <= '0;
        else if (wr_stat) ctl_q <= wdata & MASK;
    end

    // Purpose: one-cycle attention on a 0-to-1 write of the attention bit
    always_ff @(posedge clk) begin
        if (!rst_n) attn_pulse <= 1'b0;
        else        attn_pulse <= wr_stat & wdata[ST_ATTN] & ~ctl_q[ST_ATTN];
    end

    // Purpose: sticky controller interrupt flag, forced clear under board reset
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq_flag <= 1'b0;
        else if (ctl_q[ST_RESET])   irq_flag <= 1'b0;
        else if (irq_pulse)         irq_flag <= 1'b1;
        else if (irq_clear)         irq_flag <= 1'b0;
    end

endmodule

// File: rtl/nic_perr_capture.sv
// Parity error recorder: sets a sticky flag and freezes the first error's
// address, source and byte half until the host acknowledges.
// Assumes error pulses last one cycle; the address is valid with the pulse.
module nic_perr_capture
    import nic_ctl_pkg::*;
#(
    parameter int LO_W = ERR_LO_W,
    parameter int HI_W = ERR_HI_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack,
    input  logic                 err_pulse,
    input  logic [LO_W+HI_W-1:0] err_addr,
    input  logic                 err_src,
    input  logic                 err_half,
    output logic                 flag,
    output perr_rec_t            rec
);

    logic take;
    // a new record is taken when nothing is pending or the pending one is released now
    assign take = err_pulse & (~flag | ack);

    // Purpose: sticky parity flag, cleared by acknowledge unless a new error arrives
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= err_pulse | (flag & ~ack);
    end

    // Purpose: capture the failing location of the first unacknowledged error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec <= '0;
        end else if (take) begin
            rec.src  <= err_src;
            rec.half <= err_half;
            rec.lo   <= err_addr[LO_W-1:0];
            rec.hi   <= err_addr[LO_W+HI_W-1:LO_W];
        end
    end

endmodule

// File: rtl/nic_irq_combine.sv
// Combines per-source sticky flags with their enables into one request.
// Pure combinational; each source is flag AND enable.
module nic_irq_combine #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] enables,
    output logic             irq
);

    logic [N_SRC-1:0] gated;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign gated[g] = flags[g] & enables[g];
    end

    // Purpose: request when any enabled source is pending
    always_comb irq = |gated;

endmodule

// File: rtl/nic_ctl_regs.sv
// Top of the host control block: status word, parity capture registers,
// read multiplexer and combined interrupt.
// Assumes host accesses are single-cycle; reads are combinational.
module nic_ctl_regs
    import nic_ctl_pkg::*;
#(
    parameter int LO_W = ERR_LO_W,
    parameter int HI_W = ERR_HI_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [1:0]           host_sel,
    input  logic [REG_W-1:0]     host_wdata,
    output logic [REG_W-1:0]     host_rdata,
    input  logic                 ctrl_irq_pulse,
    input  logic                 par_err_pulse,
    input  logic [LO_W+HI_W-1:0] par_err_addr,
    input  logic                 par_err_src,
    input  logic                 par_err_half,
    output logic                 board_rst,
    output logic                 on_air,
    output logic                 attn_pulse,
    output logic                 p2_enable,
    output logic                 ram_256k,
    output logic [HI_W-1:0]      ext_haddr,
    output logic                 irq_out
);

    reg_sel_e          sel;
    logic              wr_stat;
    logic              ack_w;
    logic [REG_W-1:0]  ctl_w;
    logic              irq_flag_w;
    logic              perr_flag_w;
    perr_rec_t         cap_w;
    logic [REG_W-1:0]  status_rd;
    logic [REG_W-1:0]  pctrl_rd;

    assign sel     = reg_sel_e'(host_sel);
    assign wr_stat = host_wr & (sel == SEL_STATUS);
    assign ack_w   = host_wr & (sel == SEL_PCTRL) & host_wdata[PC_ACK];

    nic_ctl_status #(.W(REG_W)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_stat),
        .wdata      (host_wdata),
        .irq_pulse  (ctrl_irq_pulse),
        .ctl_q      (ctl_w),
        .irq_flag   (irq_flag_w),
        .attn_pulse (attn_pulse)
    );

    nic_perr_capture #(.LO_W(LO_W), .HI_W(HI_W)) i_perr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack       (ack_w),
        .err_pulse (par_err_pulse),
        .err_addr  (par_err_addr),
        .err_src   (par_err_src),
        .err_half  (par_err_half),
        .flag      (perr_flag_w),
        .rec       (cap_w)
    );

    nic_irq_combine #(.N_SRC(2)) i_irq (
        .flags   ({perr_flag_w, irq_flag_w}),
        .enables ({ctl_w[ST_PIEN], ctl_w[ST_IEN]}),
        .irq     (irq_out)
    );

    // Purpose: drive the board-level control outputs from the stored word
    always_comb begin
        board_rst = ctl_w[ST_RESET];
        on_air    = ctl_w[ST_ONAIR];
        p2_enable = ctl_w[ST_P2];
        ram_256k  = ctl_w[ST_RAM256];
        ext_haddr = ctl_w[HI_W-1:0];
    end

    // Purpose: assemble the status and parity control read words
    always_comb begin
        status_rd           = ctl_w;
        status_rd[ST_IFLAG] = irq_flag_w;
        status_rd[ST_PFLAG] = perr_flag_w;
        pctrl_rd            = '0;
        pctrl_rd[PC_SRC]    = cap_w.src;
        pctrl_rd[PC_HALF]   = cap_w.half;
        pctrl_rd[HI_W-1:0]  = cap_w.hi;
    end

    // Purpose: read multiplexer on the register select
    always_comb begin
        unique case (sel)
            SEL_STATUS: host_rdata = status_rd;
            SEL_PCTRL:  host_rdata = pctrl_rd;
            SEL_PADDR:  host_rdata = REG_W'(cap_w.lo);
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nic_ctl_regs_chk.sv
// Property checker for nic_ctl_regs, attached by bind.
// Observes ports and the signals passed between the submodules.
module nic_ctl_regs_chk
    import nic_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [1:0]       host_sel,
    input logic [REG_W-1:0] host_wdata,
    input logic             ctrl_irq_pulse,
    input logic             par_err_pulse,
    input logic             board_rst,
    input logic             attn_pulse,
    input logic             irq_out,
    input logic [REG_W-1:0] ctl_w,
    input logic             irq_flag_w,
    input logic             perr_flag_w,
    input perr_rec_t        cap_w
);

    logic host_ack;
    assign host_ack = host_wr && host_sel == 2'd1 && host_wdata[PC_ACK];

    p_attn_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        attn_pulse |=> !attn_pulse);

    p_attn_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        attn_pulse |-> $past(host_wr && host_sel == 2'd0 && host_wdata[ST_ATTN]));

    p_iflag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_irq_pulse && !board_rst |=> irq_flag_w);

    p_iflag_held_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst |=> !irq_flag_w);

    p_perr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_pulse |=> perr_flag_w);

    p_rec_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        perr_flag_w && !host_ack |=> $stable(cap_w));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack && !par_err_pulse |=> !perr_flag_w);

    p_perr_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        perr_flag_w && ctl_w[ST_PIEN] |-> irq_out);

endmodule

bind nic_ctl_regs nic_ctl_regs_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_wr        (host_wr),
    .host_sel       (host_sel),
    .host_wdata     (host_wdata),
    .ctrl_irq_pulse (ctrl_irq_pulse),
    .par_err_pulse  (par_err_pulse),
    .board_rst      (board_rst),
    .attn_pulse     (attn_pulse),
    .irq_out        (irq_out),
    .ctl_w          (ctl_w),
    .irq_flag_w     (irq_flag_w),
    .perr_flag_w    (perr_flag_w),
    .cap_w          (cap_w)
);

// File: tb/test_nic_ctl_regs.sv
// Bench for nic_ctl_regs: directed corner cases plus seeded random traffic,
// compared each cycle against a model written from the requirements.
module test_nic_ctl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ctrl_irq_pulse = 1'b0;
    logic        par_err_pulse = 1'b0;
    logic [19:0] par_err_addr = '0;
    logic        par_err_src = 1'b0;
    logic        par_err_half = 1'b0;
    logic        board_rst, on_air, attn_pulse, p2_enable, ram_256k, irq_out;
    logic [3:0]  ext_haddr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    logic [15:0] m_ctl;
    logic        m_iflag, m_pflag, m_attn, m_src, m_half;
    logic [3:0]  m_hi;
    logic [15:0] m_lo;

    nic_ctl_regs i_nic_ctl_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctrl_irq_pulse(ctrl_irq_pulse), .par_err_pulse(par_err_pulse),
        .par_err_addr(par_err_addr), .par_err_src(par_err_src),
        .par_err_half(par_err_half), .board_rst(board_rst), .on_air(on_air),
        .attn_pulse(attn_pulse), .p2_enable(p2_enable), .ram_256k(ram_256k),
        .ext_haddr(ext_haddr), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0: return (m_ctl & 16'hF83F) | {6'd0, m_pflag, m_iflag, 8'd0};
            2'd1: return {8'd0, m_src, m_half, 2'b00, m_hi};
            2'd2: return m_lo;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_iflag & m_ctl[12]) | (m_pflag & m_ctl[11]);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(input logic [1:0] s);
        case (s)
            2'd0: return "R4 status";
            2'd1: return "R7 parity control";
            2'd2: return "R6 parity address";
            default: return "R9 unused select";
        endcase
    endfunction

    task automatic model_reset();
        m_ctl = '0; m_iflag = 0; m_pflag = 0; m_attn = 0;
        m_src = 0; m_half = 0; m_hi = '0; m_lo = '0;
    endtask

    // one cycle: drive, clock, advance model, compare outputs
    task automatic step(input logic w, input logic [1:0] s, input logic [15:0] d,
                        input logic ip, input logic pp, input logic [19:0] pa,
                        input logic ps, input logic ph);
        logic ack;
        @(negedge clk);
        host_wr = w; host_sel = s; host_wdata = d;
        ctrl_irq_pulse = ip; par_err_pulse = pp; par_err_addr = pa;
        par_err_src = ps; par_err_half = ph;
        @(posedge clk);
        ack    = w && s == 2'd1 && d[8];
        m_attn = w && s == 2'd0 && d[13] && !m_ctl[13];
        if (m_ctl[15])                m_iflag = 1'b0;
        else if (ip)                  m_iflag = 1'b1;
        else if (w && s == 2'd0 && d[8]) m_iflag = 1'b0;
        if (pp && (!m_pflag || ack)) begin
            m_src = ps; m_half = ph; m_lo = pa[15:0]; m_hi = pa[19:16];
        end
        m_pflag = pp | (m_pflag & ~ack);
        if (w && s == 2'd0) m_ctl = d & 16'hF83F;
        #1;
        chk("R1 board_rst", {15'd0, board_rst}, {15'd0, m_ctl[15]});
        chk("R2 on_air",    {15'd0, on_air},    {15'd0, m_ctl[14]});
        chk("R2 config",    {10'd0, p2_enable, ram_256k, ext_haddr},
                            {10'd0, m_ctl[5], m_ctl[4], m_ctl[3:0]});
        chk("R3 attn_pulse", {15'd0, attn_pulse}, {15'd0, m_attn});
        chk("R8 irq_out",   {15'd0, irq_out},   {15'd0, exp_irq()});
        chk(rd_tag(s), host_rdata, exp_read(s));
    endtask

    task automatic idle(input logic [1:0] s);
        step(1'b0, s, 16'h0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        step(1'b1, s, d, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state on every select
        for (int s = 0; s < 4; s++) idle(2'(s));
        chk("R10 reset status", host_rdata, 16'h0000);

        // R3: attention only on 0-to-1
        wr(2'd0, 16'h2000);
        wr(2'd0, 16'h2000);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h2000);
        idle(2'd0);

        // R4: flag sticky, write-1 clear, pulse beats clear
        step(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
        wr(2'd0, 16'h1000);
        wr(2'd0, 16'h1100);
        step(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
        step(1'b1, 2'd0, 16'h1100, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);

        // R5: reset bit holds flag clear and ignores pulses
        wr(2'd0, 16'h9000);
        step(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0);
        idle(2'd0);
        chk("R5 flag under reset", host_rdata & 16'h0100, 16'h0000);
        wr(2'd0, 16'h0800);

        // R6: first error kept, second ignored
        step(1'b0, 2'd1, 16'h0, 1'b0, 1'b1, 20'hA_1234, 1'b1, 1'b0);
        step(1'b0, 2'd2, 16'h0, 1'b0, 1'b1, 20'h5_BEEF, 1'b0, 1'b1);
        idle(2'd1);
        wr(2'd2, 16'hFFFF);
        wr(2'd1, 16'h00FF);
        idle(2'd2);
        // R7: acknowledge clears, reads 0
        wr(2'd1, 16'h0100);
        idle(2'd0);
        // R7: acknowledge and error in the same cycle capture the new one
        step(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 20'h3_0001, 1'b0, 1'b0);
        step(1'b1, 2'd1, 16'h0100, 1'b0, 1'b1, 20'hC_7777, 1'b1, 1'b1);
        idle(2'd2);
        idle(2'd1);
        wr(2'd1, 16'hFFFF);
        idle(2'd3);
        wr(2'd0, 16'hFFFF);
        idle(2'd0);

        // random traffic
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [15:0] d;
            logic [1:0]  s;
            logic        w;
            w = ($urandom_range(0, 3) == 0);
            s = 2'($urandom_range(0, 3));
            d = 16'($urandom());
            if (s == 2'd0 && ($urandom_range(0, 3) != 0)) d[15] = 1'b0;
            step(w, s, d, ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0),
                 20'($urandom()), 1'($urandom()), 1'($urandom()));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule